// File: doc/BRIEF.md
# Guarded Non-Volatile Array Controller

The block fronts a small on-chip non-volatile store, held here as an RTL model: a main array of equal pages plus a separate user-configuration region. A single 32-bit bus port reaches the main array, the user region and a handful of control registers. A two-bit mode field decides what array traffic is allowed. In read-only mode, array writes and erase commands are dropped. Write mode lets word writes through. Erase mode lets erase commands through.

Programming behaves like flash: a write ANDs the new value into the stored word, so a write can only clear bits. Erased words read as all ones. An erase clears one page, the whole main array or only the user region, and it completes on the clock edge that accepts the command. The ready flag is therefore always set. Reset starts the model with everything erased and read-only mode selected.

Byte address map: bits [11:10] select the region (0 main, 1 user, 2 control, 3 unmapped and reads 0), and bits [9:2] give the word index. Control word offsets: 0x00 ready, 0x04 mode, 0x08 and 0x0C page erase, 0x10 erase main array, 0x14 erase user region.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, the ready register (0x800) reads 0x00000001 at all times, the mode register reads 0, and every main and user word reads 0xFFFFFFFF.
- R2: The mode register (0x804) stores bits [1:0] of the written data and reads them back zero-extended, including the value 3. Its value changes only through a write to that register.
- R3: A read accepted on clock edge k raises bus_rvalid with its bus_rdata on edge k+2. Writes never raise bus_rvalid.
- R4: In mode 1, a write to a main or user word is stored and is returned by a read issued on the very next cycle.
- R5: A write stores the bitwise AND of the written data and the current content, including when two writes to one word are back to back.
- R6: A write to a main or user word in mode 0, 2 or 3 leaves the word unchanged.
- R7: In mode 2, writing a byte address to 0x808 or to 0x80C erases the main page selected by address bits [9:8]. Other pages keep their content.
- R8: In mode 2, writing data with bit 0 set to 0x810 erases every main page and leaves the user region unchanged.
- R9: In mode 2, writing data with bit 0 set to 0x814 erases the user region and leaves the main array unchanged.
- R10: Erase commands written in mode 0, 1 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request, one transfer per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Read data arrives two edges after the request edge. The bench drives on falling edges and samples on the falling edge that follows the second rising edge, and it also checks that rvalid is low one cycle early. Writes and erases take effect on the edge that accepts them. A read started on the following cycle must already see the new content, and the bench issues such back-to-back sequences on purpose to exercise the forwarding path. Every ignored write or ignored erase is followed by a read of the word it could have changed.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    RGN_MAIN = 2'd0,
    RGN_USER = 2'd1,
    RGN_CTRL = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  localparam logic [1:0] MODE_RO = 2'd0;
  localparam logic [1:0] MODE_WR = 2'd1;
  localparam logic [1:0] MODE_ER = 2'd2;

  localparam logic [2:0] OFS_READY = 3'd0;
  localparam logic [2:0] OFS_MODE  = 3'd1;
  localparam logic [2:0] OFS_PG_A  = 3'd2;
  localparam logic [2:0] OFS_PG_B  = 3'd3;
  localparam logic [2:0] OFS_ALL   = 3'd4;
  localparam logic [2:0] OFS_USER  = 3'd5;
endpackage

// File: rtl/nvm_regs.sv
module nvm_regs import nvm_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int PG_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  region_e           region,
  input  logic [2:0]        ofs,
  input  logic [1:0]        cmd_bits,
  input  logic [PG_W-1:0]   pg_bits,
  output logic [1:0]        cfg_q,
  output logic              wr_ok,
  output logic              ers_pg_en,
  output logic [PG_W-1:0]   ers_pg,
  output logic              ers_all,
  output logic              ers_user,
  output logic [DATA_W-1:0] rdata
);
  logic ctrl_wr;
  logic er_ok;

  assign ctrl_wr = req && we && (region == RGN_CTRL);
  assign wr_ok   = (cfg_q == MODE_WR);
  assign er_ok   = (cfg_q == MODE_ER);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= MODE_RO;
    end else if (ctrl_wr && ofs == OFS_MODE) begin
      cfg_q <= cmd_bits;
    end
  end

  // Erase strobes act on the array at the edge that accepts them.
  assign ers_pg_en = ctrl_wr && er_ok && (ofs == OFS_PG_A || ofs == OFS_PG_B);
  assign ers_pg    = pg_bits;
  assign ers_all   = ctrl_wr && er_ok && (ofs == OFS_ALL)  && cmd_bits[0];
  assign ers_user  = ctrl_wr && er_ok && (ofs == OFS_USER) && cmd_bits[0];

  always_comb begin
    rdata = '0;
    case (ofs)
      OFS_READY: rdata[0]   = 1'b1;
      OFS_MODE:  rdata[1:0] = cfg_q;
      default:   rdata      = '0;
    endcase
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 256,
  parameter int PAGE_WORDS = 64,
  localparam int IDX_W     = $clog2(WORDS),
  localparam int NPAGES    = WORDS / PAGE_WORDS,
  localparam int PG_W      = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ers_pg_en,
  input  logic [PG_W-1:0]   ers_pg,
  input  logic              ers_all,
  output logic [DATA_W-1:0] view
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  live_q;
  logic [DATA_W-1:0] q_q;
  logic              q_live_q;
  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              fwd_hit_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [DATA_W-1:0] merged;

  // Content seen by the access issued last cycle.
  assign view   = fwd_hit_q ? fwd_data_q : (q_live_q ? q_q : '1);
  assign merged = view & pend_data_q;

  // Storage: one read, one write port, no reset.
  always_ff @(posedge clk) begin
    if (pend_q) mem[pend_idx_q] <= merged;
    if (acc_en) q_q <= mem[acc_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q      <= '0;
      q_live_q    <= 1'b0;
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      pend_data_q <= '0;
      fwd_hit_q   <= 1'b0;
      fwd_data_q  <= '0;
    end else begin
      pend_q      <= acc_en && acc_we;
      pend_idx_q  <= acc_idx;
      pend_data_q <= acc_wdata;
      if (acc_en) q_live_q <= live_q[acc_idx];
      fwd_hit_q   <= pend_q && acc_en && (acc_idx == pend_idx_q);
      fwd_data_q  <= merged;
      if (pend_q) live_q[pend_idx_q] <= 1'b1;
      // Erase is later in bus order than a committing write: it wins.
      for (int i = 0; i < WORDS; i++) begin
        if (ers_all || (ers_pg_en && (PG_W'(i / PAGE_WORDS) == ers_pg)))
          live_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl import nvm_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 64,
  parameter int PAGES      = 4,
  parameter int USER_WORDS = 32,
  localparam int MAIN_WORDS = PAGE_WORDS * PAGES,
  localparam int MIDX_W    = $clog2(MAIN_WORDS),
  localparam int UIDX_W    = $clog2(USER_WORDS),
  localparam int IDX_W     = (MIDX_W > UIDX_W) ? MIDX_W : UIDX_W,
  localparam int ADDR_W    = IDX_W + 4,
  localparam int PG_SH     = $clog2(PAGE_WORDS) + 2,
  localparam int MPG_W     = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata
);
  region_e           region;
  logic [1:0]        cfg_q;
  logic              wr_ok, ers_pg_en, ers_all, ers_user;
  logic [MPG_W-1:0]  ers_pg;
  logic [DATA_W-1:0] reg_rdata, main_view, user_view;
  logic              main_acc, user_acc;
  logic              rd1_q;
  region_e           sel1_q;
  logic [DATA_W-1:0] reg1_q;
  logic              unused_addr;

  assign region      = region_e'(bus_addr[ADDR_W-1 -: 2]);
  assign unused_addr = ^bus_addr;

  nvm_regs #(.DATA_W(DATA_W), .PG_W(MPG_W)) u_regs (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .region(region),
    .ofs(bus_addr[4:2]), .cmd_bits(bus_wdata[1:0]),
    .pg_bits(bus_wdata[PG_SH +: MPG_W]), .cfg_q(cfg_q), .wr_ok(wr_ok),
    .ers_pg_en(ers_pg_en), .ers_pg(ers_pg), .ers_all(ers_all),
    .ers_user(ers_user), .rdata(reg_rdata)
  );

  // Gated writes never reach the arrays.
  assign main_acc = bus_req && (region == RGN_MAIN) && (!bus_we || wr_ok);
  assign user_acc = bus_req && (region == RGN_USER) && (!bus_we || wr_ok);

  nvm_array #(.DATA_W(DATA_W), .WORDS(MAIN_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_main (
    .clk(clk), .rst(rst), .acc_en(main_acc), .acc_we(bus_we),
    .acc_idx(bus_addr[2 +: MIDX_W]), .acc_wdata(bus_wdata),
    .ers_pg_en(ers_pg_en), .ers_pg(ers_pg), .ers_all(ers_all),
    .view(main_view)
  );

  nvm_array #(.DATA_W(DATA_W), .WORDS(USER_WORDS), .PAGE_WORDS(USER_WORDS)) u_user (
    .clk(clk), .rst(rst), .acc_en(user_acc), .acc_we(bus_we),
    .acc_idx(bus_addr[2 +: UIDX_W]), .acc_wdata(bus_wdata),
    .ers_pg_en(1'b0), .ers_pg(1'b0), .ers_all(ers_user),
    .view(user_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1_q      <= 1'b0;
      sel1_q     <= RGN_NONE;
      reg1_q     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rd1_q      <= bus_req && !bus_we;
      sel1_q     <= region;
      reg1_q     <= reg_rdata;
      bus_rvalid <= rd1_q;
      if (rd1_q) begin
        case (sel1_q)
          RGN_MAIN: bus_rdata <= main_view;
          RGN_USER: bus_rdata <= user_view;
          RGN_CTRL: bus_rdata <= reg1_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [1:0]        cfg_q
);
  logic [1:0] cyc_q;
  logic       ctrl_sel, rd_ready, rd_mode, wr_mode;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign ctrl_sel = bus_req && (bus_addr[ADDR_W-1 -: 2] == 2'd2);
  assign rd_ready = ctrl_sel && !bus_we && (bus_addr[4:2] == 3'd0);
  assign rd_mode  = ctrl_sel && !bus_we && (bus_addr[4:2] == 3'd1);
  assign wr_mode  = ctrl_sel &&  bus_we && (bus_addr[4:2] == 3'd1);

  AST_RVALID_LAT: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) |-> (bus_rvalid == $past(bus_req && !bus_we, 2))); // R3

  AST_READY_ONE: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) && bus_rvalid && $past(rd_ready, 2) |-> (bus_rdata == DATA_W'(1))); // R1

  AST_MODE_READ: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd2) && bus_rvalid && $past(rd_mode, 2) |-> (bus_rdata == DATA_W'($past(cfg_q, 2)))); // R2

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 2'd1) && !$stable(cfg_q) |-> $past(wr_mode)); // R2
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
  .cfg_q(cfg_q)
);

// File: tb/test_nvm_ctrl.sv
`timescale 1ns/1ps
module test_nvm_ctrl;
  localparam logic [11:0] A_READY = 12'h800, A_MODE = 12'h804, A_PGA = 12'h808,
                          A_PGB = 12'h80C, A_ALL = 12'h810, A_USR = 12'h814;
  localparam logic [11:0] U0 = 12'h400;
  localparam logic [31:0] ERASED = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1, bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic bus_rvalid;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nvm_ctrl i_nvm_ctrl (.clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_req = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic set_mode(input logic [1:0] m);
    bus_write(A_MODE, {30'd0, m});
  endtask

  task automatic t_reset;
    bus_read(A_READY, rd); chk("R1 ready", rd, 32'h1);
    bus_read(A_MODE, rd);  chk("R1 mode", rd, 32'h0);
    bus_read(12'h0, rd);   chk("R1 main erased", rd, ERASED);
    bus_read(12'h3FC, rd); chk("R1 main last erased", rd, ERASED);
    bus_read(U0, rd);      chk("R1 user erased", rd, ERASED);
  endtask

  task automatic t_mode;
    set_mode(2'd3); bus_read(A_MODE, rd); chk("R2 mode 3", rd, 32'h3);
    bus_write(A_MODE, 32'hFFFF_FFF2); bus_read(A_MODE, rd); chk("R2 mode 2 low bits", rd, 32'h2);
    set_mode(2'd0); bus_read(A_MODE, rd); chk("R2 mode 0", rd, 32'h0);
  endtask

  task automatic t_latency;
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = A_READY;
    @(negedge clk); bus_req = 0; chk("R3 rvalid early", {31'd0, bus_rvalid}, 32'h0);
    @(negedge clk); chk("R3 rvalid on time", {31'd0, bus_rvalid}, 32'h1);
    chk("R3 data on time", bus_rdata, 32'h1);
    @(negedge clk); chk("R3 rvalid one cycle", {31'd0, bus_rvalid}, 32'h0);
    bus_write(A_MODE, 32'h0);
    @(negedge clk); chk("R3 no rvalid for write", {31'd0, bus_rvalid}, 32'h0);
  endtask

  // Write then read on the next cycle.
  task automatic wr_rd(input logic [11:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
    @(negedge clk); bus_req = 0;
    @(negedge clk); q = bus_rdata;
  endtask

  task automatic t_program;
    set_mode(2'd1);
    wr_rd(12'h014, 32'hA5A5_1234, rd); chk("R4 main immediate", rd, 32'hA5A5_1234);
    wr_rd(U0 + 12'h00C, 32'h0F0F_0F0F, rd); chk("R4 user immediate", rd, 32'h0F0F_0F0F);
  endtask

  task automatic t_and;
    bus_write(12'h014, 32'hFFFF_0000);
    bus_read(12'h014, rd); chk("R5 and merge", rd, 32'hA5A5_0000);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = 12'h018; bus_wdata = 32'hF0F0_F0F0;
    @(negedge clk); bus_wdata = 32'h3C3C_3C3C;
    @(negedge clk); bus_we = 0;
    @(negedge clk); bus_req = 0;
    @(negedge clk); chk("R5 back to back and", bus_rdata, 32'h3030_3030);
  endtask

  task automatic t_gate_write;
    for (int m = 0; m < 4; m++) begin
      if (m != 1) begin
        set_mode(m[1:0]);
        bus_write(12'h01C, 32'h0);
        bus_read(12'h01C, rd); chk($sformatf("R6 main write mode %0d", m), rd, ERASED);
        bus_write(U0 + 12'h010, 32'h0);
        bus_read(U0 + 12'h010, rd); chk($sformatf("R6 user write mode %0d", m), rd, ERASED);
      end
    end
  endtask

  task automatic fill;
    set_mode(2'd1);
    bus_write(12'h000, 32'h1); bus_write(12'h100, 32'h2);
    bus_write(12'h200, 32'h3); bus_write(12'h3FC, 32'h4);
    bus_write(U0, 32'h5);
  endtask

  task automatic t_page_erase;
    fill();
    set_mode(2'd2);
    bus_write(A_PGA, 32'h0000_0108);
    bus_read(12'h100, rd); chk("R7 page 1 erased via A", rd, ERASED);
    bus_read(12'h000, rd); chk("R7 page 0 kept", rd, 32'h1);
    bus_read(12'h200, rd); chk("R7 page 2 kept", rd, 32'h3);
    bus_write(A_PGB, 32'h0000_03FC);
    bus_read(12'h3FC, rd); chk("R7 page 3 erased via B", rd, ERASED);
    bus_read(12'h200, rd); chk("R7 page 2 still kept", rd, 32'h3);
  endtask

  task automatic t_erase_gate;
    set_mode(2'd1); bus_write(A_PGA, 32'h0);
    bus_read(12'h000, rd); chk("R10 page erase in mode 1", rd, 32'h1);
    set_mode(2'd0); bus_write(A_ALL, 32'h1);
    bus_read(12'h200, rd); chk("R10 erase all in mode 0", rd, 32'h3);
    set_mode(2'd3); bus_write(A_USR, 32'h1);
    bus_read(U0, rd); chk("R10 user erase in mode 3", rd, 32'h5);
  endtask

  task automatic t_user_erase;
    set_mode(2'd2); bus_write(A_USR, 32'h1);
    bus_read(U0, rd); chk("R9 user erased", rd, ERASED);
    bus_read(12'h000, rd); chk("R9 main kept", rd, 32'h1);
  endtask

  task automatic t_erase_all;
    set_mode(2'd1); bus_write(U0 + 12'h004, 32'h7);
    set_mode(2'd2); bus_write(A_ALL, 32'h1);
    bus_read(12'h000, rd); chk("R8 page 0 erased", rd, ERASED);
    bus_read(12'h200, rd); chk("R8 page 2 erased", rd, ERASED);
    bus_read(U0 + 12'h004, rd); chk("R8 user kept", rd, 32'h7);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_mode();
    t_latency();
    t_program();
    t_and();
    t_gate_write();
    t_page_erase();
    t_erase_gate();
    t_user_erase();
    t_erase_all();
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule